// File: doc/BRIEF.md
# Burst-Locking Write Arbiter

This block lets several bursting write hosts share one memory-mapped agent port. Each host raises a request and presents a base address, a word count, a write strobe and write data. When the port is free, a round-robin picker chooses one requester. The chosen host's signals are forwarded to the agent, and the agent's backpressure is passed back to that host alone.

Once the first word of a multi-word burst is accepted, the arbiter locks onto that host. It stays locked until the counted number of words has been accepted, including any cycles in which the host holds its strobe low. During a lock every other host sees backpressure, whatever it requests. Inside a burst the agent receives the address of each word, counting up from the base, and also the word count.

A count of zero or one is a single transfer. It takes no lock, so the arbiter chooses again on the next cycle. After each single transfer or finished burst, the round-robin search starts at the host after the one just served.

Top module: `burst_lock_arbiter`

## Requirements
- R1: With no lock held, the grant goes to the first requesting host found by searching in ascending index order (wrapping), starting at the host after the most recently served one; gnt is one-hot or zero.
- R2: After the first word of a burst with effective count above one is accepted, gnt stays on that host and the agent sees only that host's signals until the burst ends, whatever the other hosts request.
- R3: If the locked host holds its write strobe low in mid-burst, a_write is low, the lock and remaining count are held for every stall cycle, and all other hosts keep seeing h_wait high.
- R4: Word k (k = 0, 1, ...) of a burst appears on a_addr as base + k, and a_burst shows the effective count for every word of the burst.
- R5: The lock releases in the cycle after exactly the effective count of words has been accepted; a count smaller than the host's maximum (for example 3) releases after that many words.
- R6: An h_burst value of 0 or 1 is a single word: no lock is taken, a_burst shows 1, and arbitration runs again in the next cycle.
- R7: A word is accepted only in a cycle where a_write is high and a_wait is low. The granted host's h_wait equals a_wait, and every host that is not granted sees h_wait high.
- R8: During and after reset, no lock is held and the search pointer selects host 0 first. With no requests, gnt is zero, a_write is low and all h_wait bits are high.
- R9: a_write and a_wdata are the granted host's write strobe and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| h_req | input | N_HOSTS | Per-host request |
| h_write | input | N_HOSTS | Per-host write strobe (word valid) |
| h_addr | input | N_HOSTS*ADDR_W | Per-host base word address, host i at bits [i*ADDR_W +: ADDR_W] |
| h_burst | input | N_HOSTS*BC_W | Per-host word count, 0 treated as 1 |
| h_wdata | input | N_HOSTS*DATA_W | Per-host write data |
| h_wait | output | N_HOSTS | Per-host backpressure |
| gnt | output | N_HOSTS | One-hot grant |
| a_write | output | 1 | Write strobe to agent |
| a_addr | output | ADDR_W | Word address to agent |
| a_burst | output | BC_W | Effective word count of the current transfer |
| a_wdata | output | DATA_W | Write data to agent |
| a_wait | input | 1 | Agent backpressure |

## Verification
The assertions assume that h_burst does not exceed the range of BC_W and that all inputs are settled and free of X after reset. They also assume that a host's address and count are stable from its request until its first accepted word. The bench drives every input away from the clock edge, so inputs are always settled at the edge. It sweeps every count from 0 to 8 for each host, with patterns of strobe gaps and agent backpressure. It applies a long mid-burst stall only after a fresh reset, so the stalled burst is known to belong to host 0.

// File: rtl/burst_arb_pkg.sv
package burst_arb_pkg;
  function automatic int wrap_add(input int base, input int step, input int n);
    int s;
    s = base + step;
    while (s >= n) s = s - n;
    return s;
  endfunction
endpackage

// File: rtl/arb_rst_sync.sv
module arb_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick
  import burst_arb_pkg::*;
#(
  parameter int N_HOSTS = 3,
  localparam int IDX_W = (N_HOSTS > 1) ? $clog2(N_HOSTS) : 1
) (
  input  logic [N_HOSTS-1:0] req,
  input  logic [IDX_W-1:0]   last,
  output logic               valid,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    // descending step order so the smallest step wins
    for (int k = N_HOSTS; k >= 1; k--) begin
      int cand;
      cand = wrap_add(int'(last), k, N_HOSTS);
      if (req[cand]) begin
        valid = 1'b1;
        idx   = IDX_W'(cand);
      end
    end
  end
endmodule

// File: rtl/arb_host_mux.sv
module arb_host_mux #(
  parameter int N_HOSTS = 3,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int BC_W    = 4,
  localparam int IDX_W = (N_HOSTS > 1) ? $clog2(N_HOSTS) : 1
) (
  input  logic [IDX_W-1:0]          sel,
  input  logic [N_HOSTS-1:0]        write,
  input  logic [N_HOSTS*ADDR_W-1:0] addr,
  input  logic [N_HOSTS*BC_W-1:0]   burst,
  input  logic [N_HOSTS*DATA_W-1:0] wdata,
  output logic                      s_write,
  output logic [ADDR_W-1:0]         s_addr,
  output logic [BC_W-1:0]           s_bc,
  output logic [DATA_W-1:0]         s_wdata
);
  logic [BC_W-1:0] raw_bc;

  always_comb begin
    s_write = write[sel];
    s_addr  = addr[int'(sel)*ADDR_W +: ADDR_W];
    raw_bc  = burst[int'(sel)*BC_W +: BC_W];
    s_wdata = wdata[int'(sel)*DATA_W +: DATA_W];
    s_bc    = (raw_bc == '0) ? BC_W'(1) : raw_bc;
  end
endmodule

// File: rtl/arb_lock_ctrl.sv
module arb_lock_ctrl #(
  parameter int N_HOSTS = 3,
  parameter int ADDR_W  = 16,
  parameter int BC_W    = 4,
  localparam int IDX_W = (N_HOSTS > 1) ? $clog2(N_HOSTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic [BC_W-1:0]   in_bc,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              locked,
  output logic [IDX_W-1:0]  owner,
  output logic [IDX_W-1:0]  last,
  output logic [BC_W-1:0]   left,
  output logic [BC_W-1:0]   bc,
  output logic [ADDR_W-1:0] cur_addr
);
  logic              locked_d;
  logic [IDX_W-1:0]  owner_d, last_d;
  logic [BC_W-1:0]   left_d, off_d, bc_d, off_q;
  logic [ADDR_W-1:0] base_d, base_q;

  always_comb begin
    locked_d = locked;
    owner_d  = owner;
    last_d   = last;
    left_d   = left;
    off_d    = off_q;
    bc_d     = bc;
    base_d   = base_q;
    if (beat) begin
      if (!locked) begin
        if (in_bc > BC_W'(1)) begin
          locked_d = 1'b1;
          owner_d  = in_idx;
          left_d   = in_bc - BC_W'(1);
          off_d    = BC_W'(1);
          bc_d     = in_bc;
          base_d   = in_addr;
        end else begin
          last_d = in_idx;
        end
      end else begin
        left_d = left - BC_W'(1);
        off_d  = off_q + BC_W'(1);
        if (left == BC_W'(1)) begin
          locked_d = 1'b0;
          last_d   = owner;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      owner  <= '0;
      last   <= IDX_W'(N_HOSTS - 1);
      left   <= '0;
      off_q  <= '0;
      bc     <= '0;
      base_q <= '0;
    end else if (beat) begin
      locked <= locked_d;
      owner  <= owner_d;
      last   <= last_d;
      left   <= left_d;
      off_q  <= off_d;
      bc     <= bc_d;
      base_q <= base_d;
    end
  end

  assign cur_addr = base_q + ADDR_W'(off_q);
endmodule

// File: rtl/burst_lock_arbiter.sv
module burst_lock_arbiter #(
  parameter int N_HOSTS = 3,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int BC_W    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_HOSTS-1:0]        h_req,
  input  logic [N_HOSTS-1:0]        h_write,
  input  logic [N_HOSTS*ADDR_W-1:0] h_addr,
  input  logic [N_HOSTS*BC_W-1:0]   h_burst,
  input  logic [N_HOSTS*DATA_W-1:0] h_wdata,
  output logic [N_HOSTS-1:0]        h_wait,
  output logic [N_HOSTS-1:0]        gnt,
  output logic                      a_write,
  output logic [ADDR_W-1:0]         a_addr,
  output logic [BC_W-1:0]           a_burst,
  output logic [DATA_W-1:0]         a_wdata,
  input  logic                      a_wait
);
  localparam int IDX_W = (N_HOSTS > 1) ? $clog2(N_HOSTS) : 1;

  logic              rst_s;
  logic              pick_valid, sel_valid, beat;
  logic [IDX_W-1:0]  pick_idx, sel_idx;
  logic              locked;
  logic [IDX_W-1:0]  owner, last;
  logic [BC_W-1:0]   left, bc_q, m_bc;
  logic [ADDR_W-1:0] cur_addr, m_addr;
  logic              m_write;

  arb_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_s));

  arb_rr_pick #(.N_HOSTS(N_HOSTS)) u_pick (
    .req(h_req), .last(last), .valid(pick_valid), .idx(pick_idx)
  );

  assign sel_valid = locked | pick_valid;
  assign sel_idx   = locked ? owner : pick_idx;

  arb_host_mux #(.N_HOSTS(N_HOSTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BC_W(BC_W)) u_mux (
    .sel(sel_idx), .write(h_write), .addr(h_addr), .burst(h_burst), .wdata(h_wdata),
    .s_write(m_write), .s_addr(m_addr), .s_bc(m_bc), .s_wdata(a_wdata)
  );

  assign a_write = sel_valid & m_write;
  assign beat    = a_write & ~a_wait;
  assign a_addr  = locked ? cur_addr : m_addr;
  assign a_burst = locked ? bc_q : m_bc;

  arb_lock_ctrl #(.N_HOSTS(N_HOSTS), .ADDR_W(ADDR_W), .BC_W(BC_W)) u_lock (
    .clk(clk), .rst_n(rst_s), .beat(beat),
    .in_idx(sel_idx), .in_bc(m_bc), .in_addr(m_addr),
    .locked(locked), .owner(owner), .last(last), .left(left), .bc(bc_q), .cur_addr(cur_addr)
  );

  for (genvar i = 0; i < N_HOSTS; i++) begin : g_host
    assign gnt[i]    = sel_valid && (sel_idx == IDX_W'(i));
    assign h_wait[i] = ~gnt[i] | a_wait;
  end

  // R2: lock stays on its owner until the final word
  a_r2_lock_hold: assert property (@(posedge clk) disable iff (!rst_s)
    (locked && !(beat && left == BC_W'(1))) |=> (locked && $stable(owner)));
  // R3: stall cycles freeze count and address
  a_r3_stall_freeze: assert property (@(posedge clk) disable iff (!rst_s)
    (locked && !beat) |=> ($stable(left) && $stable(a_addr)));
  // R4: consecutive words of a burst go to consecutive addresses
  a_r4_seq_addr: assert property (@(posedge clk) disable iff (!rst_s)
    (beat && a_burst > BC_W'(1) && !(locked && left == BC_W'(1)))
      |=> (a_addr == $past(a_addr) + ADDR_W'(1)));
  // R5: release right after the last counted word
  a_r5_release: assert property (@(posedge clk) disable iff (!rst_s)
    (locked && beat && left == BC_W'(1)) |=> !locked);
  // R6: single words never lock
  a_r6_single_nolock: assert property (@(posedge clk) disable iff (!rst_s)
    (!locked && beat && a_burst == BC_W'(1)) |=> !locked);
  // R7: at most one host sees backpressure released, grant one-hot
  a_r7_one_host: assert property (@(posedge clk) disable iff (!rst_s)
    ($onehot0(gnt) && $countones(~h_wait) <= 1));
endmodule

// File: tb/burst_lock_arbiter_bench.sv
module burst_lock_arbiter_bench;
  localparam int N  = 3;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int BW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0]    h_req, h_write, h_wait, gnt;
  logic [N*AW-1:0] h_addr;
  logic [N*BW-1:0] h_burst;
  logic [N*DW-1:0] h_wdata;
  logic a_write, a_wait;
  logic [AW-1:0] a_addr;
  logic [BW-1:0] a_burst;
  logic [DW-1:0] a_wdata;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // reference state
  bit m_locked;
  int m_owner, m_last, m_left, m_bc, m_off;
  int m_base;

  always #5 clk = ~clk;

  burst_lock_arbiter #(.N_HOSTS(N), .ADDR_W(AW), .DATA_W(DW), .BC_W(BW)) u_burst_lock_arbiter (
    .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_write(h_write), .h_addr(h_addr),
    .h_burst(h_burst), .h_wdata(h_wdata), .h_wait(h_wait), .gnt(gnt),
    .a_write(a_write), .a_addr(a_addr), .a_burst(a_burst), .a_wdata(a_wdata), .a_wait(a_wait)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int eff(input int b);
    return (b == 0) ? 1 : b;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    h_req = '0; h_write = '0; a_wait = 1'b0;
    h_addr = '0; h_burst = '0; h_wdata = '0;
    m_locked = 1'b0; m_owner = 0; m_last = N - 1; m_left = 0; m_bc = 0; m_off = 0; m_base = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R8 reset gnt", int'(gnt), 0);
    chk("R8 reset a_write", int'(a_write), 0);
    chk("R8 reset h_wait", int'(h_wait), (1 << N) - 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R8 post-reset gnt idle", int'(gnt), 0);
    chk("R8 post-reset h_wait", int'(h_wait), (1 << N) - 1);
  endtask

  // one cycle: drive at negedge, check, then advance reference
  task automatic step(input int scen, input int c, input bit just_rel, output bit rel);
    int g, eb, exp_addr, exp_bc;
    bit gv, wr;
    string tg;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      int b;
      h_req[i]   = 1'b1;
      h_write[i] = (((c * 7 + i * 3) % 5) != 0);
      b = (scen + i * 4) % 9;
      if (scen == 27 && i == 0) b = 8;
      h_burst[i*BW +: BW] = BW'(b);
      h_addr[i*AW +: AW]  = AW'(16'h1000 * i + scen * 16'h10);
      h_wdata[i*DW +: DW] = DW'(16'h1000 * i + c);
    end
    a_wait = ((c % 4) == 3);
    if (scen == 27) begin
      a_wait = 1'b0;
      if (c >= 3 && c <= 15) h_write[0] = 1'b0;
    end
    #1;
    gv = 1'b0; g = 0;
    if (m_locked) begin gv = 1'b1; g = m_owner; end
    else begin
      for (int k = N; k >= 1; k--) begin
        int cd;
        cd = (m_last + k) % N;
        if (h_req[cd]) begin gv = 1'b1; g = cd; end
      end
    end
    wr = gv && h_write[g];
    eb = eff(int'(h_burst[g*BW +: BW]));
    exp_addr = m_locked ? ((m_base + m_off) & 16'hFFFF) : int'(h_addr[g*AW +: AW]);
    exp_bc   = m_locked ? m_bc : eb;
    tg = m_locked ? "R2 grant held" : (just_rel ? "R5 regrant after release" : "R1 round-robin grant");
    chk(tg, int'(gnt), gv ? (1 << g) : 0);
    chk((m_locked && !h_write[g]) ? "R3 stall a_write" : "R9 a_write", int'(a_write), int'(wr));
    chk("R9 a_wdata", int'(a_wdata), int'(h_wdata[g*DW +: DW]));
    chk("R4 a_addr", int'(a_addr), exp_addr);
    chk((!m_locked && eb == 1) ? "R6 single a_burst" : "R4 a_burst", int'(a_burst), exp_bc);
    chk(m_locked ? "R3 others wait / R7" : "R7 h_wait", int'(h_wait),
        ((1 << N) - 1) & ~((gv && !a_wait) ? (1 << g) : 0));
    rel = 1'b0;
    if (wr && !a_wait) begin
      if (!m_locked) begin
        if (eb > 1) begin
          m_locked = 1'b1; m_owner = g; m_left = eb - 1; m_bc = eb; m_off = 1;
          m_base = int'(h_addr[g*AW +: AW]);
        end else begin
          m_last = g; rel = 1'b1;
        end
      end else begin
        m_left--; m_off++;
        if (m_left == 0) begin m_locked = 1'b0; m_last = m_owner; rel = 1'b1; end
      end
    end
  endtask

  initial begin
    bit jr, r;
    rst_n = 1'b0;
    do_reset();
    // R8: with all hosts requesting, host 0 is chosen first
    @(negedge clk);
    h_req = '1; h_write = '0; a_wait = 1'b0;
    #1;
    chk("R8 first grant host0", int'(gnt), 1);
    for (int s = 0; s < 28; s++) begin
      if (s == 27) do_reset();
      jr = 1'b0;
      for (int c = 0; c < 40; c++) begin
        step(s, c, jr, r);
        jr = r;
      end
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule